// File: doc/BRIEF.md
# Switch Connection Request Sequencer

This block sits on the transmit side of a port card, between the transmit FIFO and the serial link to a crosspoint switch. Before a packet is released, the user logic presents a 32-bit connection-request word. The block accepts it, then drives request words onto the link, watches for the switch's grant acknowledge, and holds the FIFO read enable low while the connection is pending. It also raises a retransmit-mode flag whenever the same request is being repeated.

Three disciplines are supported, chosen by the mode field of the request. Camp-on repeats the request until it is granted. If a retry budget runs out first, the block widens the request so that any single granted output is enough. Multicast with recast sends a fixed burst of requests and then returns to idle. Multi-queue sends one request and lets a bounded number of data words pass while it waits. If the next packet's header shows up before the grant, it starts repeating the request.

The request input is a valid/ready stream. A word is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the block is idle, so a source holding `req_valid` waits until the current sequence ends. The link output has no back-pressure: one word type and one word are produced on every cycle. Acknowledge, header-detect and delay-enable are plain level inputs sampled on each clock edge.

Top module: `crq_sequencer`

## Requirements
- R1: After a synchronous reset, and at any time in reset, the block is idle. `out_kind` is IDLE (2'b00), `out_word` is zero, `rd_en` is 1, `retx` is 0 and `req_ready` is 1.
- R2: An accepted request whose port bitmap (bits 15:0) is all zero, or whose mode field (bits 18:17) is 2'b11, is dropped. On the next cycle the block is still idle with `rd_en` high.
- R3: Request word layout: bits 15:0 form the port bitmap (bit 15 addresses port 0, bit 0 addresses port 15), bit 16 is all-or-any (1 = all outputs), bits 18:17 are the mode and bits 21:19 are the count. `req_ready` is low whenever a sequence is active. Every emitted request word (`out_kind` REQ = 2'b01) carries the held bitmap, mode and count in those positions, with bits 31:22 zero.
- R4: Camp-on (mode 2'b00) starts on the cycle after acceptance. A REQ word is output every cycle, with `rd_en` low and `retx` high, up to and including the cycle in which `ack` is seen.
- R5: In camp-on, the first count×RETRY_STEP request words keep the requested all-or-any bit. Every later word has bit 16 cleared.
- R6: When `ack` is seen in a waiting state (camp-on, multi-queue wait or multi-queue retry) with `dly_en` low, the block is idle on the next cycle with `rd_en` high and `retx` low.
- R7: When `ack` is seen with `dly_en` high, the block outputs IDLE with `rd_en` low and `retx` low for exactly HOLD_N cycles. It then returns to idle with `rd_en` high.
- R8: Multicast with recast (mode 2'b01) outputs exactly RECAST_CNT REQ words with `retx` high and `rd_en` low, then goes idle. `ack` has no effect on this sequence.
- R9: Multi-queue (mode 2'b10) outputs one REQ word with `rd_en` low and `retx` low. It then outputs IDLE with `rd_en` high for PASS_D cycles, followed by `rd_en` low until `ack` or `hdr_det` arrives.
- R10: In the multi-queue wait, `hdr_det` without `ack` moves the block to repeating REQ words with `rd_en` low and `retx` high until `ack`. When `ack` and `hdr_det` arrive together, `ack` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request word offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_word | input | 32 | Connection-request word |
| ack | input | 1 | Grant acknowledge from the switch |
| hdr_det | input | 1 | Next packet header seen at the parallel input |
| dly_en | input | 1 | Hold read enable for HOLD_N cycles after a grant |
| rd_en | output | 1 | Read enable to the transmit FIFO |
| retx | output | 1 | Retransmit-mode flag, high while a request is repeated |
| out_kind | output | 2 | Link word type: 00 IDLE, 01 request |
| out_word | output | 32 | Request word toward the switch, zero when idle |

## Verification
Some properties are checked on every cycle: a request word never appears with read enable high; the retransmit flag implies a request word; idle outputs are all zero; a widened request never narrows again within a sequence; a dropped null request leaves the block ready; and a grant without delay releases read enable on the next cycle. Other behaviour can only be shown by the bench's scenarios, because each depends on counting cycles against a request's fields. This covers the exact cycle at which the fallback clears the all-or-any bit, the length of the post-grant hold, the recast burst length, the number of words passed in multi-queue, and the priority of acknowledge over header-detect.

// File: rtl/crq_pkg.sv
package crq_pkg;
  localparam int WORD_W   = 32;
  localparam int MAP_W    = 16;
  localparam int AOA_BIT  = 16;
  localparam int MODE_LSB = 17;
  localparam int CT_LSB   = 19;
  localparam int CT_W     = 3;
  localparam int USED_W   = CT_LSB + CT_W;

  typedef enum logic [1:0] {
    LK_IDLE = 2'b00,
    LK_REQ  = 2'b01
  } link_kind_e;

  typedef enum logic [1:0] {
    DISC_CAMP   = 2'b00,
    DISC_RECAST = 2'b01,
    DISC_MQ     = 2'b10,
    DISC_RSVD   = 2'b11
  } disc_e;

  typedef struct packed {
    logic [CT_W-1:0]  ct;
    disc_e            disc;
    logic             all_req;
    logic [MAP_W-1:0] ports;
  } req_fields_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAMP, ST_RECAST, ST_MQ_SEND, ST_MQ_WAIT, ST_MQ_RETRY, ST_HOLD
  } seq_st_e;
endpackage

// File: rtl/crq_decode.sv
module crq_decode
  import crq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output req_fields_t       fields,
  output logic              is_null
);
  always_comb begin
    fields.ports   = word[MAP_W-1:0];
    fields.all_req = word[AOA_BIT];
    fields.disc    = disc_e'(word[MODE_LSB +: 2]);
    fields.ct      = word[CT_LSB +: CT_W];
    is_null        = (fields.ports == '0) || (fields.disc == DISC_RSVD);
  end
endmodule

// File: rtl/crq_timer.sv
module crq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          zero,
  output logic          one
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (dec && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
  assign one  = (cnt == CW'(1));
endmodule

// File: rtl/crq_sequencer.sv
module crq_sequencer
  import crq_pkg::*;
#(
  parameter int RETRY_STEP = 2,
  parameter int HOLD_N     = 3,
  parameter int RECAST_CNT = 5,
  parameter int PASS_D     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_word,
  input  logic              ack,
  input  logic              hdr_det,
  input  logic              dly_en,
  output logic              rd_en,
  output logic              retx,
  output logic [1:0]        out_kind,
  output logic [WORD_W-1:0] out_word
);
  localparam int RETRY_MAX = ((1 << CT_W) - 1) * RETRY_STEP;
  localparam int M1   = (RETRY_MAX > HOLD_N) ? RETRY_MAX : HOLD_N;
  localparam int M2   = (M1 > RECAST_CNT) ? M1 : RECAST_CNT;
  localparam int MAXV = (M2 > PASS_D) ? M2 : PASS_D;
  localparam int CW   = $clog2(MAXV + 1);

  seq_st_e     state, state_nx;
  req_fields_t held;
  req_fields_t in_f;
  logic        in_null;
  logic        accept;
  logic        t_load, t_dec, t_zero, t_one;
  logic [CW-1:0] t_val, t_cnt;
  logic        is_req, aoa_eff;

  crq_decode u_dec (
    .word    (req_word),
    .fields  (in_f),
    .is_null (in_null)
  );

  crq_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .cnt      (t_cnt),
    .zero     (t_zero),
    .one      (t_one)
  );

  assign accept = req_valid && (state == ST_IDLE);

  always_comb begin
    state_nx = state;
    t_load   = 1'b0;
    t_val    = '0;
    t_dec    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept && !in_null) begin
          t_load = 1'b1;
          unique case (in_f.disc)
            DISC_CAMP: begin
              state_nx = ST_CAMP;
              t_val    = CW'(int'(in_f.ct) * RETRY_STEP);
            end
            DISC_RECAST: begin
              state_nx = ST_RECAST;
              t_val    = CW'(RECAST_CNT);
            end
            default: begin
              state_nx = ST_MQ_SEND;
              t_val    = CW'(PASS_D);
            end
          endcase
        end
      end
      ST_CAMP, ST_MQ_WAIT, ST_MQ_RETRY: begin
        if (ack) begin
          if (dly_en) begin
            state_nx = ST_HOLD;
            t_load   = 1'b1;
            t_val    = CW'(HOLD_N);
          end else begin
            state_nx = ST_IDLE;
          end
        end else if (state == ST_MQ_WAIT && hdr_det) begin
          state_nx = ST_MQ_RETRY;
        end else if (state != ST_MQ_RETRY) begin
          t_dec = 1'b1;
        end
      end
      ST_RECAST: begin
        t_dec = 1'b1;
        if (t_one) state_nx = ST_IDLE;
      end
      ST_MQ_SEND: state_nx = ST_MQ_WAIT;
      ST_HOLD: begin
        t_dec = 1'b1;
        if (t_one) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      held  <= '0;
    end else begin
      state <= state_nx;
      if (accept && !in_null) held <= in_f;
    end
  end

  always_comb begin
    is_req    = (state == ST_CAMP) || (state == ST_RECAST) ||
                (state == ST_MQ_SEND) || (state == ST_MQ_RETRY);
    req_ready = (state == ST_IDLE);
    rd_en     = (state == ST_IDLE) || ((state == ST_MQ_WAIT) && !t_zero);
    retx      = (state == ST_CAMP) || (state == ST_RECAST) || (state == ST_MQ_RETRY);
    aoa_eff   = held.all_req && !((state == ST_CAMP) && t_zero);
    out_kind  = is_req ? LK_REQ : LK_IDLE;
    out_word  = '0;
    if (is_req)
      out_word[USED_W-1:0] = {held.ct, held.disc, aoa_eff, held.ports};
  end
endmodule

// File: rtl/crq_sequencer_chk.sv
module crq_sequencer_chk
  import crq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [WORD_W-1:0] req_word,
  input logic              ack,
  input logic              hdr_det,
  input logic              dly_en,
  input logic              rd_en,
  input logic              retx,
  input logic [1:0]        out_kind,
  input logic [WORD_W-1:0] out_word
);
  AST_REQ_GATES_READ: assert property (@(posedge clk) disable iff (rst)
    (out_kind == LK_REQ) |-> !rd_en);  // R4
  AST_RETX_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    retx |-> (out_kind == LK_REQ));  // R10
  AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_kind == LK_IDLE) |-> (out_word == '0));  // R1
  AST_READY_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (out_kind == LK_IDLE && rd_en && !retx));  // R3
  AST_REQ_HAS_PORTS: assert property (@(posedge clk) disable iff (rst)
    (out_kind == LK_REQ) |-> (out_word[MAP_W-1:0] != '0));  // R3
  AST_NULL_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_word[MAP_W-1:0] == '0) |=> req_ready);  // R2
  AST_FALLBACK_STICKS: assert property (@(posedge clk) disable iff (rst)
    (out_kind == LK_REQ && retx && !out_word[AOA_BIT] && !ack)
      |=> (out_kind != LK_REQ || !out_word[AOA_BIT]));  // R5
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (retx && ack && !dly_en && out_word[MODE_LSB +: 2] != 2'b01)
      |=> (rd_en && req_ready));  // R6
endmodule

bind crq_sequencer crq_sequencer_chk u_chk (.*);

// File: tb/tb_crq_sequencer.sv
module tb_crq_sequencer;
  localparam int STEP  = 2;
  localparam int HOLDN = 3;
  localparam int RCNT  = 5;
  localparam int PASSD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_word = '0;
  logic        ack = 1'b0;
  logic        hdr_det = 1'b0;
  logic        dly_en = 1'b0;
  logic        rd_en, retx;
  logic [1:0]  out_kind;
  logic [31:0] out_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  crq_sequencer dut (.*);

  always #5 clk = ~clk;

  // {ct[3], aoa[1], bitmap[16], ack_at[8], dly[1]}
  localparam logic [28:0] VEC [6] = '{
    {3'd2, 1'b1, 16'h8000, 8'd1, 1'b0},
    {3'd1, 1'b1, 16'h0001, 8'd5, 1'b0},
    {3'd0, 1'b1, 16'h00FF, 8'd2, 1'b1},
    {3'd3, 1'b0, 16'hF0F0, 8'd7, 1'b1},
    {3'd7, 1'b1, 16'hFFFF, 8'd3, 1'b0},
    {3'd2, 1'b1, 16'h1234, 8'd0, 1'b1}
  };

  function automatic logic [31:0] mk(input logic [2:0] ct, input logic [1:0] md,
                                     input logic aoa, input logic [15:0] map);
    return {10'd0, ct, md, aoa, map};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(out_kind == 2'b00 && rd_en && !retx && req_ready && out_word == 0, tag,
        {out_kind, rd_en, retx, req_ready}, {2'b00, 3'b101});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick();
    chk_idle("R1 in reset");
    tick();
    rst = 1'b0;
    tick();
    chk_idle("R1 after reset");

    // camp-on vectors
    foreach (VEC[v]) begin
      logic [2:0]  ct;
      logic        aoa, dly;
      logic [15:0] map;
      int          ack_at, lim;
      ct     = VEC[v][28:26];
      aoa    = VEC[v][25];
      map    = VEC[v][24:9];
      ack_at = int'(VEC[v][8:1]);
      dly    = VEC[v][0];
      lim    = int'(ct) * STEP;
      dly_en = dly;
      req_word = mk(ct, 2'b00, aoa, map);
      req_valid = 1'b1;
      tick();
      req_valid = 1'b0;
      for (int k = 0; k < 40; k++) begin
        chk(out_kind == 2'b01 && !rd_en && retx, "R4 camp request",
            {out_kind, rd_en, retx}, {2'b01, 2'b01});
        chk(out_word[16] == (aoa && k < lim), "R5 all-or-any", out_word[16], aoa && k < lim);
        chk(out_word == mk(ct, 2'b00, out_word[16], map) && !req_ready, "R3 word fields",
            out_word, mk(ct, 2'b00, out_word[16], map));
        if (k == ack_at) begin
          ack = 1'b1;
          tick();
          ack = 1'b0;
          break;
        end
        tick();
      end
      if (dly) begin
        for (int i = 0; i < HOLDN; i++) begin
          chk(out_kind == 2'b00 && !rd_en && !retx, "R7 hold",
              {out_kind, rd_en, retx}, 4'b0000);
          tick();
        end
        chk_idle("R7 release");
      end else begin
        chk_idle("R6 release");
      end
      dly_en = 1'b0;
      tick();
    end

    // null bitmap
    req_word = mk(3'd2, 2'b00, 1'b1, 16'h0000);
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    chk_idle("R2 null bitmap");
    tick();
    chk_idle("R2 null bitmap later");

    // reserved mode
    req_word = mk(3'd1, 2'b11, 1'b1, 16'hFFFF);
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    chk_idle("R2 reserved mode");

    // recast, ack held high and ignored
    ack = 1'b1;
    req_word = mk(3'd0, 2'b01, 1'b1, 16'h0F00);
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    for (int k = 0; k < RCNT; k++) begin
      chk(out_kind == 2'b01 && retx && !rd_en && out_word == mk(3'd0, 2'b01, 1'b1, 16'h0F00),
          "R8 recast word", out_word, mk(3'd0, 2'b01, 1'b1, 16'h0F00));
      tick();
    end
    chk_idle("R8 recast end");
    ack = 1'b0;

    // multi-queue, grant without header
    req_word = mk(3'd4, 2'b10, 1'b1, 16'h0003);
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    chk(out_kind == 2'b01 && !rd_en && !retx, "R9 mq request",
        {out_kind, rd_en, retx}, {2'b01, 2'b00});
    tick();
    for (int i = 0; i < PASSD; i++) begin
      chk(out_kind == 2'b00 && rd_en && !retx, "R9 mq pass", {out_kind, rd_en, retx}, 4'b0010);
      tick();
    end
    for (int i = 0; i < 2; i++) begin
      chk(out_kind == 2'b00 && !rd_en && !retx, "R9 mq stall", {out_kind, rd_en, retx}, 4'b0000);
      tick();
    end
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk_idle("R6 mq release");

    // multi-queue, header before grant
    req_word = mk(3'd0, 2'b10, 1'b0, 16'h4000);
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    tick();
    chk(rd_en && out_kind == 2'b00, "R9 mq wait", rd_en, 1);
    hdr_det = 1'b1;
    tick();
    hdr_det = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(out_kind == 2'b01 && !rd_en && retx && out_word == mk(3'd0, 2'b10, 1'b0, 16'h4000),
          "R10 mq retry", out_word, mk(3'd0, 2'b10, 1'b0, 16'h4000));
      tick();
    end
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk_idle("R10 retry release");

    // multi-queue, ack and header together
    req_word = mk(3'd0, 2'b10, 1'b1, 16'h0010);
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    tick();
    ack = 1'b1;
    hdr_det = 1'b1;
    tick();
    ack = 1'b0;
    hdr_det = 1'b0;
    chk_idle("R10 ack priority");

    // reset during camp-on
    req_word = mk(3'd7, 2'b00, 1'b1, 16'h0101);
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk_idle("R1 reset mid sequence");

    finish_run();
  end
endmodule